// File: doc/BRIEF.md
# Two-Way Lockable Page Translation Cache

This block holds recently used virtual-to-physical page translations in a 64-set, two-way array of 16KB pages. A lookup presents a 32-bit virtual address and an address-space identifier. One cycle later the block answers with a hit, the physical page number and the attribute flags, or with a miss. A maintenance side installs new translations and ejects single translations by virtual page.

Any installed entry can be pinned. Replacement never chooses a pinned entry, so software can reserve a fixed slot in each of several sets. A pinned entry stays resident until an explicit invalidate removes it. If both ways of a set are pinned and the new page is not already present, the fill is refused and flagged. An entry marked global matches every address-space identifier. A fill whose page and identifier are already present rewrites that entry where it sits, so a set never holds the same translation twice.

Top module: `page_tlb`

## Requirements
- R1: After reset every entry is empty, and every lookup misses. A lookup presented with `lk_en` in one cycle is answered in the next cycle. `rsp_valid` is high in that cycle only.
- R2: A hit returns the stored `rsp_ppn` and `rsp_flags` with `rsp_hit` high. A miss returns `rsp_hit` low with `rsp_ppn` and `rsp_flags` both zero.
- R3: The set is selected by VA[19:14] and the tag is VA[31:20]. VA[13:0] has no effect on any operation.
- R4: An entry hits only when its stored identifier equals the presented one, unless the entry was filled with `fill_global` high, in which case any identifier hits.
- R5: A fill that matches no entry goes to an empty way, way 0 first. If both ways are occupied, it goes to the least recently used way. A lookup hit or an accepted fill makes the other way of that set least recently used.
- R6: An entry filled with `fill_lock` high is never chosen as a victim. A fill into a set with one pinned way replaces the unpinned way.
- R7: A non-matching fill into a set whose two ways are both pinned changes nothing. `fill_err` is high in the cycle after that fill and low after every other fill.
- R8: A fill whose tag and identifier match a resident entry overwrites that entry in place, and the other way is kept.
- R9: An invalidate removes the entry that a lookup with the same address and identifier would hit, even when that entry is pinned. An invalidate that matches no entry changes nothing.
- R10: A lookup and a fill to the same set in the same cycle return the contents the set held before the fill.
- R11: When an invalidate and a fill arrive in the same cycle, the invalidate is carried out and the fill is discarded without raising `fill_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_ctx | input | 8 | Lookup address-space identifier |
| fill_en | input | 1 | Fill request |
| fill_va | input | 32 | Virtual address of the page being installed |
| fill_ctx | input | 8 | Identifier stored with the entry |
| fill_ppn | input | 18 | Physical page number to store |
| fill_flags | input | 4 | Attribute flags to store |
| fill_global | input | 1 | Entry matches any identifier |
| fill_lock | input | 1 | Entry is pinned against replacement |
| inv_en | input | 1 | Invalidate request |
| inv_va | input | 32 | Virtual address to eject |
| inv_ctx | input | 8 | Identifier to eject |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 18 | Physical page number on a hit |
| rsp_flags | output | 4 | Flags on a hit |
| fill_err | output | 1 | Previous-cycle fill refused |

## Verification
Every result of this block is registered once. A lookup answer and the refusal flag of a fill both appear at the first clock edge after the request. A fill or an invalidate alters the array at that same edge, so a lookup issued in any later cycle sees the change. The bench drives each request on a falling edge and removes it on the next falling edge, and it samples the response and `fill_err` at that point, exactly one rising edge after the request. The same-cycle cases raise both strobes on one falling edge. A lookup in that cycle therefore reads the array before the write, and a follow-up lookup in a later cycle reads it afterwards.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 14;
  localparam int SET_W = 6;
  localparam int CTX_W = 8;
  localparam int PPN_W = 18;
  localparam int FLG_W = 4;
  localparam int TAG_W = VA_W - OFF_W - SET_W;
  localparam int SETS  = 1 << SET_W;

  typedef struct packed {
    logic             valid;
    logic             locked;
    logic             global;
    logic [CTX_W-1:0] ctx;
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic [FLG_W-1:0] flags;
  } tlb_entry_t;

  function automatic logic [SET_W-1:0] va_set(input logic [VA_W-1:0] va);
    return va[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] va_tag(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: TAG_W];
  endfunction

  function automatic logic entry_match(input tlb_entry_t e,
                                       input logic [TAG_W-1:0] tag,
                                       input logic [CTX_W-1:0] ctx);
    return e.valid && (e.tag == tag) && (e.global || (e.ctx == ctx));
  endfunction
endpackage

// File: rtl/ptlb_way_store.sv
module ptlb_way_store
  import ptlb_pkg::*;
#(
  parameter int NSETS = SETS,
  localparam int IW = $clog2(NSETS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [IW-1:0] lk_set,
  output tlb_entry_t lk_entry,
  input  logic [IW-1:0] mt_set,
  output tlb_entry_t mt_entry,
  input  logic       wr_en,
  input  logic [IW-1:0] wr_set,
  input  tlb_entry_t wr_entry
);
  tlb_entry_t mem [NSETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_set] <= wr_entry;
    end
  end

  assign lk_entry = mem[lk_set];
  assign mt_entry = mem[mt_set];

  // R2: a write lands in the addressed set at the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_set)] == $past(wr_entry)));
endmodule

// File: rtl/ptlb_repl.sv
module ptlb_repl
  import ptlb_pkg::*;
#(
  parameter int NSETS = SETS,
  localparam int IW = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_upd,
  input  logic [IW-1:0] lk_set,
  input  logic          lk_way,
  input  logic          fill_upd,
  input  logic [IW-1:0] fill_set,
  input  logic          fill_way,
  input  logic [IW-1:0] q_set,
  output logic          q_lru
);
  logic [NSETS-1:0] lru;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lru <= '0;
    end else begin
      if (lk_upd)   lru[lk_set]   <= ~lk_way;
      if (fill_upd) lru[fill_set] <= ~fill_way;
    end
  end

  assign q_lru = lru[q_set];

  // R5: a fill leaves the other way as least recently used
  p_fill_flips_lru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_upd |=> (lru[$past(fill_set)] == ~$past(fill_way)));
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim
  import ptlb_pkg::*;
(
  input  tlb_entry_t e0,
  input  tlb_entry_t e1,
  input  logic       hit0,
  input  logic       hit1,
  input  logic       lru,
  output logic       way,
  output logic       refuse
);
  logic lock_lru, lock_oth;

  always_comb begin
    lock_lru = lru ? e1.locked : e0.locked;
    lock_oth = lru ? e0.locked : e1.locked;
    refuse   = 1'b0;
    way      = 1'b0;
    if (hit0)           way = 1'b0;
    else if (hit1)      way = 1'b1;
    else if (!e0.valid) way = 1'b0;
    else if (!e1.valid) way = 1'b1;
    else if (!lock_lru) way = lru;
    else if (!lock_oth) way = ~lru;
    else                refuse = 1'b1;
  end

  // R6: a new page never displaces a valid pinned entry
  always_comb begin
    if (!refuse && !hit0 && !hit1)
      p_no_locked_victim_r6: assert (way ? !(e1.valid && e1.locked)
                                         : !(e0.valid && e0.locked));
  end
endmodule

// File: rtl/page_tlb.sv
module page_tlb
  import ptlb_pkg::*;
#(
  localparam int NSETS = SETS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic             fill_en,
  input  logic [VA_W-1:0]  fill_va,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [FLG_W-1:0] fill_flags,
  input  logic             fill_global,
  input  logic             fill_lock,
  input  logic             inv_en,
  input  logic [VA_W-1:0]  inv_va,
  input  logic [CTX_W-1:0] inv_ctx,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic [FLG_W-1:0] rsp_flags,
  output logic             fill_err
);
  tlb_entry_t lk_e [2];
  tlb_entry_t mt_e [2];
  logic [1:0] lk_hit, mt_hit, wr_en;
  logic [SET_W-1:0] lk_set, mt_set;
  logic [TAG_W-1:0] lk_tag, mt_tag;
  logic [VA_W-1:0]  mt_va;
  logic [CTX_W-1:0] mt_ctx;
  logic inv_do, fill_do, fill_accept, v_way, refuse, lru_q, lk_hit_any;
  tlb_entry_t new_e, wr_e;

  assign lk_set = va_set(lk_va);
  assign lk_tag = va_tag(lk_va);
  assign mt_va  = inv_en ? inv_va  : fill_va;
  assign mt_ctx = inv_en ? inv_ctx : fill_ctx;
  assign mt_set = va_set(mt_va);
  assign mt_tag = va_tag(mt_va);

  assign inv_do      = inv_en;
  assign fill_do     = fill_en && !inv_en;
  assign fill_accept = fill_do && !refuse;

  always_comb begin
    new_e        = '0;
    new_e.valid  = 1'b1;
    new_e.locked = fill_lock;
    new_e.global = fill_global;
    new_e.ctx    = fill_ctx;
    new_e.tag    = va_tag(fill_va);
    new_e.ppn    = fill_ppn;
    new_e.flags  = fill_flags;
  end
  assign wr_e = inv_do ? '0 : new_e;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign lk_hit[w] = lk_en && entry_match(lk_e[w], lk_tag, lk_ctx);
    assign mt_hit[w] = entry_match(mt_e[w], mt_tag, mt_ctx);
    assign wr_en[w]  = (inv_do && mt_hit[w]) ||
                       (fill_accept && (v_way == w[0]));
    ptlb_way_store #(.NSETS(NSETS)) u_store (
      .clk(clk), .rst_n(rst_n),
      .lk_set(lk_set), .lk_entry(lk_e[w]),
      .mt_set(mt_set), .mt_entry(mt_e[w]),
      .wr_en(wr_en[w]), .wr_set(mt_set), .wr_entry(wr_e)
    );
  end

  assign lk_hit_any = |lk_hit;

  ptlb_victim u_victim (
    .e0(mt_e[0]), .e1(mt_e[1]), .hit0(mt_hit[0]), .hit1(mt_hit[1]),
    .lru(lru_q), .way(v_way), .refuse(refuse)
  );

  ptlb_repl #(.NSETS(NSETS)) u_repl (
    .clk(clk), .rst_n(rst_n),
    .lk_upd(lk_hit_any), .lk_set(lk_set), .lk_way(lk_hit[1]),
    .fill_upd(fill_accept), .fill_set(mt_set), .fill_way(v_way),
    .q_set(mt_set), .q_lru(lru_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_flags <= '0;
      fill_err  <= 1'b0;
    end else begin
      rsp_valid <= lk_en;
      rsp_hit   <= lk_hit_any;
      rsp_ppn   <= lk_hit[1] ? lk_e[1].ppn : (lk_hit[0] ? lk_e[0].ppn : '0);
      rsp_flags <= lk_hit[1] ? lk_e[1].flags : (lk_hit[0] ? lk_e[0].flags : '0);
      fill_err  <= fill_do && refuse;
    end
  end

  // R1: an answer appears exactly one cycle after each request
  p_rsp_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> rsp_valid);
  p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> !rsp_valid);
  // R2: a miss carries no page number or flags
  p_miss_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_flags == '0));
  // R8: a translation is never held in both ways of a set
  p_no_dup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit) && $onehot0(mt_hit));
  // R7, R11: the refusal flag only follows a fill that was not overridden
  p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $past(fill_en && !inv_en));
endmodule

// File: tb/page_tlb_bench.sv
module page_tlb_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_en = 0, fill_en = 0, inv_en = 0;
  logic [31:0] lk_va = 0, fill_va = 0, inv_va = 0;
  logic [7:0]  lk_ctx = 0, fill_ctx = 0, inv_ctx = 0;
  logic [17:0] fill_ppn = 0;
  logic [3:0]  fill_flags = 0;
  logic fill_global = 0, fill_lock = 0;
  logic rsp_valid, rsp_hit, fill_err;
  logic [17:0] rsp_ppn;
  logic [3:0]  rsp_flags;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_tlb u_page_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_en(lk_en), .lk_va(lk_va), .lk_ctx(lk_ctx),
    .fill_en(fill_en), .fill_va(fill_va), .fill_ctx(fill_ctx),
    .fill_ppn(fill_ppn), .fill_flags(fill_flags),
    .fill_global(fill_global), .fill_lock(fill_lock),
    .inv_en(inv_en), .inv_va(inv_va), .inv_ctx(inv_ctx),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_flags(rsp_flags), .fill_err(fill_err)
  );

  function automatic logic [31:0] mkva(input logic [11:0] tag, input logic [5:0] s,
                                       input logic [13:0] off);
    return {tag, s, off};
  endfunction
  function automatic logic [17:0] pp(input logic [11:0] tag, input logic [5:0] s);
    return {tag, s};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] ctx, input logic eh,
                        input logic [17:0] ep, input logic [3:0] ef, input string req);
    logic [17:0] xp;
    logic [3:0]  xf;
    xp = eh ? ep : 18'h0;
    xf = eh ? ef : 4'h0;
    @(negedge clk);
    lk_en = 1; lk_va = va; lk_ctx = ctx;
    @(negedge clk);
    lk_en = 0;
    check(rsp_valid === 1'b1 && rsp_hit === eh && rsp_ppn === xp && rsp_flags === xf,
          req, {9'h0, rsp_valid, rsp_hit, rsp_ppn, rsp_flags},
          {9'h0, 1'b1, eh, xp, xf});
  endtask

  task automatic fill(input logic [31:0] va, input logic [7:0] ctx, input logic [17:0] p,
                      input logic [3:0] f, input logic g, input logic lk,
                      input logic eerr, input string req);
    @(negedge clk);
    fill_en = 1; fill_va = va; fill_ctx = ctx; fill_ppn = p; fill_flags = f;
    fill_global = g; fill_lock = lk;
    @(negedge clk);
    fill_en = 0;
    check(fill_err === eerr, req, {31'h0, fill_err}, {31'h0, eerr});
  endtask

  task automatic inval(input logic [31:0] va, input logic [7:0] ctx);
    @(negedge clk);
    inv_en = 1; inv_va = va; inv_ctx = ctx;
    @(negedge clk);
    inv_en = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(rsp_valid === 1'b0 && fill_err === 1'b0, "R1 reset outputs",
          {30'h0, rsp_valid, fill_err}, 32'h0);
    for (int s = 0; s < 64; s++)
      lookup(mkva(12'h001, s[5:0], 14'h0), 8'd3, 0, 0, 0, "R1 empty after reset");

    // R2, R3, R5: fill both ways of every set, then read them back
    for (int s = 0; s < 64; s++) begin
      fill(mkva(12'h001, s[5:0], 14'h0), 8'd3, pp(12'h001, s[5:0]), s[3:0], 0, 0, 0,
           "R5 fill empty way");
      fill(mkva(12'h002, s[5:0], 14'h3ff), 8'd3, pp(12'h002, s[5:0]), ~s[3:0], 0, 0, 0,
           "R5 fill second way");
    end
    for (int s = 0; s < 64; s++) begin
      lookup(mkva(12'h001, s[5:0], 14'h2a5), 8'd3, 1, pp(12'h001, s[5:0]), s[3:0],
             "R3 offset ignored, R2 hit data");
      lookup(mkva(12'h002, s[5:0], 14'h0), 8'd3, 1, pp(12'h002, s[5:0]), ~s[3:0],
             "R2 hit way two");
      lookup(mkva(12'h001, s[5:0], 14'h0), 8'd4, 0, 0, 0, "R4 context mismatch");
    end
    lookup(mkva(12'h003, 6'd1, 14'h0), 8'd3, 0, 0, 0, "R3 tag mismatch");

    // R5: LRU replacement in set 5
    lookup(mkva(12'h001, 6'd5, 0), 8'd3, 1, pp(12'h001, 6'd5), 4'd5, "R5 touch way0");
    fill(mkva(12'h003, 6'd5, 0), 8'd3, pp(12'h003, 6'd5), 4'h9, 0, 0, 0, "R5 replace");
    lookup(mkva(12'h002, 6'd5, 0), 8'd3, 0, 0, 0, "R5 LRU evicted");
    lookup(mkva(12'h001, 6'd5, 0), 8'd3, 1, pp(12'h001, 6'd5), 4'd5, "R5 MRU kept");
    lookup(mkva(12'h003, 6'd5, 0), 8'd3, 1, pp(12'h003, 6'd5), 4'h9, "R5 new entry");

    // R4, R9: global entry in a cleared set
    inval(mkva(12'h001, 6'd20, 0), 8'd3);
    inval(mkva(12'h002, 6'd20, 0), 8'd3);
    lookup(mkva(12'h001, 6'd20, 0), 8'd3, 0, 0, 0, "R9 invalidate removes");
    fill(mkva(12'h0a0, 6'd20, 0), 8'd3, pp(12'h0a0, 6'd20), 4'h1, 1, 0, 0, "R4 global fill");
    lookup(mkva(12'h0a0, 6'd20, 0), 8'd9, 1, pp(12'h0a0, 6'd20), 4'h1, "R4 global any ctx");

    // R6: one pinned way in set 7
    inval(mkva(12'h001, 6'd7, 0), 8'd3);
    inval(mkva(12'h002, 6'd7, 0), 8'd3);
    fill(mkva(12'h011, 6'd7, 0), 8'd3, pp(12'h011, 6'd7), 4'h2, 0, 1, 0, "R6 pin");
    fill(mkva(12'h012, 6'd7, 0), 8'd3, pp(12'h012, 6'd7), 4'h3, 0, 0, 0, "R6 second");
    lookup(mkva(12'h012, 6'd7, 0), 8'd3, 1, pp(12'h012, 6'd7), 4'h3, "R6 touch unpinned");
    fill(mkva(12'h013, 6'd7, 0), 8'd3, pp(12'h013, 6'd7), 4'h4, 0, 0, 0, "R6 third");
    lookup(mkva(12'h011, 6'd7, 0), 8'd3, 1, pp(12'h011, 6'd7), 4'h2, "R6 pinned kept");
    lookup(mkva(12'h012, 6'd7, 0), 8'd3, 0, 0, 0, "R6 unpinned replaced");
    lookup(mkva(12'h013, 6'd7, 0), 8'd3, 1, pp(12'h013, 6'd7), 4'h4, "R6 new present");

    // R7, R9: both ways pinned in set 9
    inval(mkva(12'h001, 6'd9, 0), 8'd3);
    inval(mkva(12'h002, 6'd9, 0), 8'd3);
    fill(mkva(12'h021, 6'd9, 0), 8'd3, pp(12'h021, 6'd9), 4'h5, 0, 1, 0, "R7 pin a");
    fill(mkva(12'h022, 6'd9, 0), 8'd3, pp(12'h022, 6'd9), 4'h6, 0, 1, 0, "R7 pin b");
    fill(mkva(12'h023, 6'd9, 0), 8'd3, pp(12'h023, 6'd9), 4'h7, 0, 0, 1, "R7 refused");
    lookup(mkva(12'h023, 6'd9, 0), 8'd3, 0, 0, 0, "R7 refused not stored");
    lookup(mkva(12'h021, 6'd9, 0), 8'd3, 1, pp(12'h021, 6'd9), 4'h5, "R7 pin a kept");
    lookup(mkva(12'h022, 6'd9, 0), 8'd3, 1, pp(12'h022, 6'd9), 4'h6, "R7 pin b kept");
    inval(mkva(12'h021, 6'd9, 0), 8'd3);
    lookup(mkva(12'h021, 6'd9, 0), 8'd3, 0, 0, 0, "R9 pinned ejected");
    fill(mkva(12'h023, 6'd9, 0), 8'd3, pp(12'h023, 6'd9), 4'h7, 0, 0, 0, "R7 room again");
    lookup(mkva(12'h023, 6'd9, 0), 8'd3, 1, pp(12'h023, 6'd9), 4'h7, "R7 stored after eject");

    // R8: overwrite in place in set 11
    fill(mkva(12'h001, 6'd11, 0), 8'd3, 18'h3abcd, 4'hc, 0, 0, 0, "R8 refill");
    lookup(mkva(12'h001, 6'd11, 0), 8'd3, 1, 18'h3abcd, 4'hc, "R8 new value");
    lookup(mkva(12'h002, 6'd11, 0), 8'd3, 1, pp(12'h002, 6'd11), ~4'd11, "R8 other kept");

    // R9: invalidate with another context leaves the entry
    inval(mkva(12'h001, 6'd14, 0), 8'd4);
    lookup(mkva(12'h001, 6'd14, 0), 8'd3, 1, pp(12'h001, 6'd14), 4'd14, "R9 ctx mismatch");

    // R10: same-cycle lookup and fill in set 12
    @(negedge clk);
    lk_en = 1; lk_va = mkva(12'h001, 6'd12, 0); lk_ctx = 8'd3;
    fill_en = 1; fill_va = mkva(12'h001, 6'd12, 0); fill_ctx = 8'd3;
    fill_ppn = 18'h15555; fill_flags = 4'ha; fill_global = 0; fill_lock = 0;
    @(negedge clk);
    lk_en = 0; fill_en = 0;
    check(rsp_hit === 1'b1 && rsp_ppn === pp(12'h001, 6'd12), "R10 old value",
          {13'h0, rsp_hit, rsp_ppn}, {13'h0, 1'b1, pp(12'h001, 6'd12)});
    lookup(mkva(12'h001, 6'd12, 0), 8'd3, 1, 18'h15555, 4'ha, "R10 new value after");
    @(negedge clk);
    lk_en = 1; lk_va = mkva(12'h033, 6'd12, 0); lk_ctx = 8'd3;
    fill_en = 1; fill_va = mkva(12'h033, 6'd12, 0); fill_ppn = 18'h2aaaa;
    @(negedge clk);
    lk_en = 0; fill_en = 0;
    check(rsp_hit === 1'b0, "R10 miss before fill", {31'h0, rsp_hit}, 32'h0);

    // R11: invalidate and fill together in set 13
    @(negedge clk);
    inv_en = 1; inv_va = mkva(12'h001, 6'd13, 0); inv_ctx = 8'd3;
    fill_en = 1; fill_va = mkva(12'h044, 6'd13, 0); fill_ctx = 8'd3;
    fill_ppn = 18'h01234; fill_flags = 4'h3;
    @(negedge clk);
    inv_en = 0; fill_en = 0;
    check(fill_err === 1'b0, "R11 no error", {31'h0, fill_err}, 32'h0);
    lookup(mkva(12'h001, 6'd13, 0), 8'd3, 0, 0, 0, "R11 invalidate done");
    lookup(mkva(12'h044, 6'd13, 0), 8'd3, 0, 0, 0, "R11 fill discarded");

    finish_run();
  end
endmodule